// File: doc/BRIEF.md
# Codec Status Word Sequencer

This block produces the 16-bit status word that an audio codec sends back to its host in every sample period of a time-slotted serial link. Once per sample it captures the host's control fields and the two per-channel overrange codes, and it registers a new status word. The status word carries four things: the two overrange codes, a fixed revision ID, an autocalibrate-in-progress flag and an initialization flag.

The calibration flag starts when the host leaves mode-change-enable. It then stays high for a number of samples that depends on whether autocalibration was requested. After a sample-rate change, the initialization flag is placed on one chosen sample, which depends on the frame format and on which half of a two-sample frame carried the change. That sample is the last valid one. A single-cycle shutdown request then follows, and the sequencer freezes until reset.

All inputs except clock and reset are sampled in the cycle where `smp_stb_i` is high. The status word changes on the next clock edge and holds until the next accepted strobe.

Top module: `codec_status_seq`

## Requirements
- R1: After reset, `stat_word_o` is 16'h0100 and `halt_req_o` is low.
- R2: The status word has the following bit layout:
  - bit 0 is the initialization flag and bit 1 is the calibration flag.
  - bits 3:2 hold the left overrange code and bits 5:4 hold the right overrange code.
  - bits 11:8 hold the revision ID 4'b0001.
  - bit 13, the request echo, and every other bit read zero.
- R3: The overrange codes present at a strobe appear unchanged in the status word for that sample. Codes 0 to 3 mean, in order: below -1 dB, -1 dB to 0 dB, 0 dB to +1 dB, and above +1 dB.
- R4: At the first strobe where `mce_i` is low after a strobe where it was high, the calibration flag of that sample's word is set.
- R5: Once started, the calibration flag stays high for exactly 384 consecutive samples if `acal_i` was 1 at the starting strobe, and for exactly 128 if it was 0.
- R6: A strobe with `mce_i` high clears the calibration flag in that sample's word and cancels any count in progress.
- R7: The initialization flag is set only after a strobe with `rate_chg_i` high. With `one_smp_frame_i` = 1 it is set in the word of the next sample.
- R8: With `one_smp_frame_i` = 0, the flag is set at the next strobe that has `upper_half_i` high:
  - a rate change in a first-half sample (`upper_half_i` = 0) sets it in the next sample;
  - a rate change in a second-half sample sets it two samples later.
- R9: `halt_req_o` is high for exactly one cycle: the cycle after the first cycle in which the word shows the initialization flag.
- R10: Once the initialization flag is shown, further strobes are ignored and the status word is frozen until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| smp_stb_i | input | 1 | One-cycle strobe per sample period |
| upper_half_i | input | 1 | Sample lies in slots 16-31 of a two-sample frame |
| mce_i | input | 1 | Mode-change-enable from the control word |
| acal_i | input | 1 | Autocalibrate request from the control word |
| rate_chg_i | input | 1 | A new sample rate was programmed in this sample |
| one_smp_frame_i | input | 1 | Frame format: 1 = one sample per frame, 0 = two |
| ovr_left_i | input | 2 | Left overrange code |
| ovr_right_i | input | 2 | Right overrange code |
| stat_word_o | output | 16 | Status word for the current sample |
| halt_req_o | output | 1 | Single-cycle serial shutdown request |

## Verification
A wrong calibration counter shows up as a calibration flag that ends one sample early or late. That error appears only hundreds of samples after mode-change-enable falls, so both full durations are counted edge to edge, together with a cancellation in mid-count. A bad pending flag in the initialization scheduler puts the flag one sample early or late, or never, and the frame freezes at the wrong sample. Each frame format and slot half is therefore checked sample by sample, and the shutdown pulse and freeze are checked in the cycles right after.

// File: rtl/codec_stat_pkg.sv
package codec_stat_pkg;
  localparam int unsigned STAT_W = 16;
  localparam logic [3:0] REV_ID = 4'b0001;

  typedef struct packed {
    logic [1:0] rsvd_hi;
    logic       rreq;
    logic       rsvd_12;
    logic [3:0] rev;
    logic [1:0] rsvd_lo;
    logic [1:0] ovr_r;
    logic [1:0] ovr_l;
    logic       aci;
    logic       init;
  } stat_word_t;
endpackage

// File: rtl/aci_timer.sv
module aci_timer #(
  parameter int unsigned LONG_SMP  = 384,
  parameter int unsigned SHORT_SMP = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  input  logic mce_i,
  input  logic acal_i,
  output logic aci_o
);
  localparam int unsigned CNT_W = $clog2(LONG_SMP + 1);

  logic             mce_q;
  logic             aci_q;
  logic [CNT_W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mce_q <= 1'b0;
      aci_q <= 1'b0;
      rem_q <= '0;
    end else if (stb_i) begin
      mce_q <= mce_i;
      if (mce_i) begin
        aci_q <= 1'b0;
        rem_q <= '0;
      end else if (mce_q) begin
        aci_q <= 1'b1;
        rem_q <= acal_i ? CNT_W'(LONG_SMP - 1) : CNT_W'(SHORT_SMP - 1);
      end else if (rem_q != '0) begin
        aci_q <= 1'b1;
        rem_q <= rem_q - 1'b1;
      end else begin
        aci_q <= 1'b0;
      end
    end
  end

  assign aci_o = aci_q;

  p_aci_cancel_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i && mce_i |=> !aci_o);
  p_aci_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i && !mce_i && mce_q |=> aci_o);
  p_aci_run_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i && !mce_i && !mce_q && rem_q != '0 |=> aci_o);
  p_aci_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_i |=> $stable(aci_o));
endmodule

// File: rtl/init_sched.sv
module init_sched (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  input  logic upper_i,
  input  logic rate_chg_i,
  input  logic one_smp_i,
  output logic init_o
);
  logic pend_q;
  logic init_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      init_q <= 1'b0;
    end else if (stb_i) begin
      if (pend_q && (one_smp_i || upper_i)) begin
        init_q <= 1'b1;
        pend_q <= 1'b0;
      end else if (rate_chg_i) begin
        pend_q <= 1'b1;
      end
    end
  end

  assign init_o = init_q;

  p_init_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i && !pend_q |=> !init_o);
  p_init_half_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i && pend_q && !one_smp_i && !upper_i |=> !init_o);
  p_init_fire_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i && pend_q && (one_smp_i || upper_i) |=> init_o);
endmodule

// File: rtl/codec_status_seq.sv
module codec_status_seq
  import codec_stat_pkg::*;
#(
  parameter int unsigned LONG_SMP  = 384,
  parameter int unsigned SHORT_SMP = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_stb_i,
  input  logic              upper_half_i,
  input  logic              mce_i,
  input  logic              acal_i,
  input  logic              rate_chg_i,
  input  logic              one_smp_frame_i,
  input  logic [1:0]        ovr_left_i,
  input  logic [1:0]        ovr_right_i,
  output logic [STAT_W-1:0] stat_word_o,
  output logic              halt_req_o
);
  logic       init_w, aci_w, stb_eff;
  logic [1:0] ovr_l_q, ovr_r_q;
  logic       init_d_q, halt_q;
  stat_word_t word;

  // strobes die once the last valid word is out
  assign stb_eff = smp_stb_i & ~init_w;

  aci_timer #(.LONG_SMP(LONG_SMP), .SHORT_SMP(SHORT_SMP)) i_aci_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .stb_i (stb_eff),
    .mce_i (mce_i),
    .acal_i(acal_i),
    .aci_o (aci_w)
  );

  init_sched i_init_sched (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stb_i     (stb_eff),
    .upper_i   (upper_half_i),
    .rate_chg_i(rate_chg_i),
    .one_smp_i (one_smp_frame_i),
    .init_o    (init_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_l_q  <= '0;
      ovr_r_q  <= '0;
      init_d_q <= 1'b0;
      halt_q   <= 1'b0;
    end else begin
      if (stb_eff) begin
        ovr_l_q <= ovr_left_i;
        ovr_r_q <= ovr_right_i;
      end
      init_d_q <= init_w;
      halt_q   <= init_w & ~init_d_q;
    end
  end

  always_comb begin
    word       = '0;
    word.init  = init_w;
    word.aci   = aci_w;
    word.ovr_l = ovr_l_q;
    word.ovr_r = ovr_r_q;
    word.rev   = REV_ID;
  end

  assign stat_word_o = word;
  assign halt_req_o  = halt_q;

  p_halt_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_req_o |=> !halt_req_o);
  p_halt_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_req_o |-> stat_word_o[0]);
  p_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_word_o[0] |=> $stable(stat_word_o));
endmodule

// File: tb/test_codec_status_seq.sv
module test_codec_status_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        smp_stb_i = 1'b0, upper_half_i = 1'b0, mce_i = 1'b0, acal_i = 1'b0;
  logic        rate_chg_i = 1'b0, one_smp_frame_i = 1'b1;
  logic [1:0]  ovr_left_i = '0, ovr_right_i = '0;
  logic [15:0] stat_word_o;
  logic        halt_req_o;

  int checks = 0;
  int errors = 0;
  logic [15:0] got;

  always #2 clk_i = ~clk_i;

  codec_status_seq i_codec_status_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .smp_stb_i(smp_stb_i), .upper_half_i(upper_half_i),
    .mce_i(mce_i), .acal_i(acal_i), .rate_chg_i(rate_chg_i),
    .one_smp_frame_i(one_smp_frame_i), .ovr_left_i(ovr_left_i),
    .ovr_right_i(ovr_right_i), .stat_word_o(stat_word_o), .halt_req_o(halt_req_o)
  );

  // {half, mce, acal, rate_chg, frs, ovr_l, ovr_r} -> expected word
  localparam int NV = 6;
  localparam logic [8:0]  VEC_IN [NV] = '{
    9'b0_0_0_0_1_00_00, 9'b1_0_1_0_0_01_00, 9'b0_0_0_0_1_10_01,
    9'b1_0_0_0_0_11_11, 9'b0_0_1_0_1_00_10, 9'b1_0_0_0_1_11_00};
  localparam logic [15:0] VEC_EXP [NV] = '{
    16'h0100, 16'h0104, 16'h0118, 16'h013C, 16'h0120, 16'h010C};

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    smp_stb_i = 1'b0; mce_i = 1'b0; acal_i = 1'b0; rate_chg_i = 1'b0;
    ovr_left_i = '0; ovr_right_i = '0; upper_half_i = 1'b0; one_smp_frame_i = 1'b1;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  // one sample: strobe for a cycle, word read one cycle later
  task automatic smp(input logic half, input logic mce, input logic acal, input logic rc,
                     input logic frs, input logic [1:0] ol, input logic [1:0] orr);
    upper_half_i = half; mce_i = mce; acal_i = acal; rate_chg_i = rc;
    one_smp_frame_i = frs; ovr_left_i = ol; ovr_right_i = orr;
    smp_stb_i = 1'b1;
    @(negedge clk_i);
    smp_stb_i = 1'b0; rate_chg_i = 1'b0;
    got = stat_word_o;
    @(negedge clk_i);
  endtask

  task automatic aci_run(input logic acal, input int exp_len, input string req);
    int n;
    do_reset();
    smp(0, 1, acal, 0, 1, 0, 0);
    chk("R6 mce high", {15'd0, got[1]}, 16'd0);
    smp(0, 0, acal, 0, 1, 0, 0);
    chk("R4 aci start", got, 16'h0102);
    n = 1;
    for (int i = 0; i < 400; i++) begin
      smp(0, 0, 0, 0, 1, 0, 0);
      if (got[1]) n++;
    end
    chk(req, 16'(n), 16'(exp_len));
    chk("R5 aci ended", got, 16'h0100);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 reset word", stat_word_o, 16'h0100);
    chk("R1 reset halt", {15'd0, halt_req_o}, 16'd0);

    // R2 R3 table
    for (int i = 0; i < NV; i++) begin
      smp(VEC_IN[i][8], VEC_IN[i][7], VEC_IN[i][6], VEC_IN[i][5], VEC_IN[i][4],
          VEC_IN[i][3:2], VEC_IN[i][1:0]);
      chk("R2/R3 vector", got, VEC_EXP[i]);
    end

    aci_run(1'b1, 384, "R5 long count");
    aci_run(1'b0, 128, "R5 short count");

    // R6 cancel mid-count
    do_reset();
    smp(0, 1, 1, 0, 1, 0, 0);
    smp(0, 0, 1, 0, 1, 0, 0);
    smp(0, 0, 0, 0, 1, 0, 0);
    chk("R4 aci running", got, 16'h0102);
    smp(0, 1, 0, 0, 1, 0, 0);
    chk("R6 cancel", got, 16'h0100);
    smp(0, 1, 0, 0, 1, 0, 0);
    smp(0, 1, 0, 0, 1, 0, 0);
    chk("R6 stays low", got, 16'h0100);

    // R7 one sample per frame, then R9 R10
    do_reset();
    smp(0, 0, 0, 1, 1, 0, 0);
    chk("R7 no init on change sample", got, 16'h0100);
    upper_half_i = 1'b0; ovr_left_i = 2'd2; ovr_right_i = 2'd1; one_smp_frame_i = 1'b1;
    smp_stb_i = 1'b1;
    @(negedge clk_i);
    smp_stb_i = 1'b0;
    chk("R7 init next sample", stat_word_o, 16'h0119);
    chk("R9 halt not yet", {15'd0, halt_req_o}, 16'd0);
    @(negedge clk_i);
    chk("R9 halt pulse", {15'd0, halt_req_o}, 16'd1);
    @(negedge clk_i);
    chk("R9 halt one cycle", {15'd0, halt_req_o}, 16'd0);
    smp(1, 1, 1, 1, 0, 3, 3);
    chk("R10 frozen", got, 16'h0119);
    chk("R10 halt stays low", {15'd0, halt_req_o}, 16'd0);

    // R8 first half change
    do_reset();
    smp(0, 0, 0, 1, 0, 0, 0);
    chk("R8 first half change sample", got, 16'h0100);
    smp(1, 0, 0, 0, 0, 0, 0);
    chk("R8 init in second half", got, 16'h0101);

    // R8 second half change
    do_reset();
    smp(1, 0, 0, 1, 0, 0, 0);
    chk("R8 second half change sample", got, 16'h0100);
    smp(0, 0, 0, 0, 0, 0, 0);
    chk("R8 not in next first half", got, 16'h0100);
    smp(1, 0, 0, 0, 0, 1, 1);
    chk("R8 init next frame second half", got, 16'h0115);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule